// File: doc/BRIEF.md
# Two-Wire Serial Slave with Configuration Register Bank

This block is a target on a two-wire serial bus (SCL clock line, SDA data line). An external controller uses it to load and read back a small bank of byte-wide configuration registers. Both bus lines are oversampled in a faster system clock domain. The block only ever pulls SDA low, through an open-drain enable, and the bus pull-up supplies the high level. Every register value is also presented in parallel on an output vector, so neighbouring logic can use the configuration directly.

A transfer begins with a start condition and a device-address byte. On a write, the first payload byte is a register index, and each byte after it is stored at that index, which then steps forward. A read first writes the index, then issues a repeated start and the address with the read flag set. The block returns one register per byte, MSB first, and keeps returning bytes while the controller acknowledges them. Unknown indices, writes beyond the last register and reads beyond the last register each have a defined outcome. A start or stop condition seen at any point abandons the transfer in progress.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, register n holds 0xA0 + n, for n = 0 to 7, and the SDA pull-low enable is inactive.
- R2: The first byte after a start is taken MSB first as a 7-bit address followed by a direction bit (1 = read, 0 = write). The address is 0b011010x, with bit 0 taken from the `addr_sel` strap (0x35 when the strap is 1, 0x34 when it is 0). On a match the block pulls SDA low during the ninth clock pulse. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R3: In a write, the first payload byte is the register index. Indices 0x00 to 0x07 are acknowledged. Any larger index gets no acknowledge, and no later byte of that transfer is acknowledged or stored.
- R4: Each further write byte is acknowledged and stored at the current index, and the index then advances by one.
- R5: A write byte that arrives after register 0x07 has been written is not stored and not acknowledged, and the block stops responding until the next start.
- R6: After a repeated start with the read flag, the block drives the register at the current index MSB first. Each controller acknowledge causes the next index to be returned.
- R7: In a read, once index 0x07 has been returned, each further acknowledged byte returns register 0x07 again.
- R8: After the controller leaves the ninth bit of a read byte high (no acknowledge), the block keeps SDA released until a start or stop.
- R9: A start condition at any point abandons the current transfer without storing a partial byte, and begins a new address phase.
- R10: A stop condition at any point returns the block to idle with SDA released, and a partly received byte is discarded.
- R11: The SDA pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled |
| addr_sel | input | 1 | Strap that supplies bit 0 of the device address |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| regs_o | output | 64 | Register contents; register n occupies bits [8n+7:8n] |

## Verification
A fault in the byte engine's bit counter or state shows up at the very next ninth clock pulse: an acknowledge appears where none belongs or goes missing, or read data comes back shifted by one bit. A wrong index pointer stays hidden on writes until the stop, when `regs_o` shows a byte in the wrong slot. On reads it shows in the first returned byte. Faulty handling of start or stop conditions is exposed by the following transfer, which must behave as if it started from idle.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_SUB,
      ST_SACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_WAIT
   } rb_state_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
   parameter int         NUM_REGS = 8,
   parameter logic [7:0] RST_BASE = 8'hA0,
   localparam int        PW       = i2c_rb_pkg::idx_bits(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PW-1:0]         wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [PW-1:0]         rd_addr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_o
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_BASE + 8'(g);
         else if (wr_en && wr_addr == PW'(g))
            q <= wr_data;
      end
      assign regs_o[g*8 +: 8] = q;

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == PW'(g)) |=> (q == $past(wr_data))); // R4
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == PW'(i)) rd_data = regs_o[i*8 +: 8];
   end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
   parameter int         NUM_REGS    = 8,
   parameter logic [7:0] RST_BASE    = 8'hA0,
   parameter logic [6:0] DEV_ADDR    = 7'b0110100,
   parameter int         STRAP_BIT   = 0,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  addr_sel,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] regs_o
);
   import i2c_rb_pkg::*;

   localparam int          PW  = idx_bits(NUM_REGS);
   localparam logic [PW-1:0] TOP = PW'(NUM_REGS - 1);

   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
      $error("i2c_regbank_slave: NUM_REGS must be 2..256");
   end
   if (STRAP_BIT < 0 || STRAP_BIT > 6) begin : g_bad_strap
      $error("i2c_regbank_slave: STRAP_BIT must be 0..6");
   end

   // index 0 = SCL, index 1 = SDA
   logic [1:0] line_in, lvl, rse, fll;
   assign line_in = {sda_i, scl_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (line_in[l]),
         .level_o(lvl[l]),
         .rise_o (rse[l]),
         .fall_o (fll[l])
      );
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   assign scl_s     = lvl[0];
   assign sda_s     = lvl[1];
   assign scl_rise  = rse[0];
   assign scl_fall  = fll[0];
   assign start_det = fll[1] & scl_s;
   assign stop_det  = rse[1] & scl_s;

   logic [6:0] dev_addr;
   always_comb begin
      dev_addr            = DEV_ADDR;
      dev_addr[STRAP_BIT] = addr_sel;
   end

   rb_state_e     state;
   logic [3:0]    cnt;
   logic [7:0]    rx, tx;
   logic [PW-1:0] ptr, nxt_ptr, rd_addr;
   logic          past, rw, mack, byte_done, wr_en;
   logic [7:0]    rd_data;

   assign byte_done = scl_fall && (cnt == 4'd8);
   assign nxt_ptr   = (ptr == TOP) ? TOP : ptr + 1'b1;
   assign rd_addr   = (state == ST_RACK) ? nxt_ptr : ptr;
   assign wr_en     = (state == ST_WDAT) && byte_done && !past;

   i2c_rb_regs #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(ptr),
      .wr_data(rx),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .regs_o (regs_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         rx     <= '0;
         tx     <= '0;
         ptr    <= '0;
         past   <= 1'b0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         cnt    <= '0;
         sda_oe <= 1'b0;
      end else begin
         if ((state == ST_ADDR || state == ST_SUB || state == ST_WDAT)
             && scl_rise && cnt != 4'd8) begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 1'b1;
         end
         case (state)
            ST_ADDR: if (byte_done) begin
               if (rx[7:1] == dev_addr) begin
                  rw     <= rx[0];
                  sda_oe <= 1'b1;
                  state  <= ST_AACK;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_AACK: if (scl_fall) begin
               cnt <= '0;
               if (rw) begin
                  tx     <= rd_data;
                  sda_oe <= ~rd_data[7];
                  state  <= ST_RDAT;
               end else begin
                  sda_oe <= 1'b0;
                  state  <= ST_SUB;
               end
            end
            ST_SUB: if (byte_done) begin
               if (int'(rx) < NUM_REGS) begin
                  ptr    <= rx[PW-1:0];
                  past   <= 1'b0;
                  sda_oe <= 1'b1;
                  state  <= ST_SACK;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_SACK, ST_WACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               cnt    <= '0;
               state  <= ST_WDAT;
            end
            ST_WDAT: if (byte_done) begin
               if (!past) begin
                  sda_oe <= 1'b1;
                  state  <= ST_WACK;
                  if (ptr == TOP) past <= 1'b1;
                  else            ptr  <= ptr + 1'b1;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_RDAT: if (scl_fall) begin
               if (cnt == 4'd7) begin
                  sda_oe <= 1'b0;
                  state  <= ST_RACK;
               end else begin
                  tx     <= {tx[6:0], 1'b0};
                  sda_oe <= ~tx[6];
                  cnt    <= cnt + 1'b1;
               end
            end
            ST_RACK: begin
               if (scl_rise) mack <= ~sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     ptr    <= nxt_ptr;
                     tx     <= rd_data;
                     sda_oe <= ~rd_data[7];
                     cnt    <= '0;
                     state  <= ST_RDAT;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s); // R11
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe)); // R10
   AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !stop_det) |=> (state == ST_ADDR && cnt == 4'd0)); // R9
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_oe); // R8
   AST_PAST_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDAT && byte_done && past && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe)); // R5
endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8 * CLK_PERIOD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        addr_sel = 1'b1;
   logic        sda_oe;
   logic [63:0] regs_o;
   logic        sda_bus;

   assign sda_bus = sda_m & ~sda_oe;

   i2c_regbank_slave dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl),
      .sda_i   (sda_bus),
      .addr_sel(addr_sel),
      .sda_oe  (sda_oe),
      .regs_o  (regs_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      string      tag;
      logic [7:0] val;
   } item_t;

   item_t      exp_q[$];
   logic [7:0] obs_q[$];
   int         checks = 0;
   int         failures = 0;
   int         oe_hi_changes = 0;
   logic [7:0] model [8];
   logic       done = 1'b0;

   // scoreboard monitor
   always @(negedge clk) begin
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
         item_t      e;
         logic [7:0] a;
         e = exp_q.pop_front();
         a = obs_q.pop_front();
         checks++;
         if (a !== e.val) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", e.tag, a, e.val);
         end
      end
   end

   // R11: enable must not move while SCL is high
   always @(sda_oe) if (rst_n && scl === 1'b1) oe_hi_changes++;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic chk_bank(input string tag);
      for (int n = 0; n < 8; n++) chk(tag, regs_o[n*8 +: 8], model[n]);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; #(Q);
      scl = 1'b1; #(2*Q);
      scl = 1'b0; #(Q);
   endtask

   task automatic start_c();
      sda_m = 1'b1; #(Q);
      scl = 1'b1; #(Q);
      sda_m = 1'b0; #(Q);
      scl = 1'b0; #(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; #(Q);
      scl = 1'b1; #(Q);
      sda_m = 1'b1; #(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string tag);
      logic got;
      exp_q.push_back('{tag, {7'd0, exp_ack}});
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      sda_m = 1'b1; #(Q);
      scl = 1'b1; #(Q);
      got = ~sda_bus; #(Q);
      scl = 1'b0; #(Q);
      obs_q.push_back({7'd0, got});
   endtask

   task automatic rd_byte(input logic [7:0] exp, input logic give_ack, input string tag);
      logic [7:0] v;
      exp_q.push_back('{tag, exp});
      sda_m = 1'b1;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         #(Q); scl = 1'b1; #(Q);
         v = {v[6:0], sda_bus}; #(Q);
         scl = 1'b0; #(Q);
      end
      sda_m = ~give_ack; #(Q);
      scl = 1'b1; #(2*Q);
      scl = 1'b0; #(Q);
      sda_m = 1'b1;
      obs_q.push_back(v);
   endtask

   task automatic summary();
      #(4*CLK_PERIOD);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      for (int n = 0; n < 8; n++) model[n] = 8'hA0 + 8'(n);
      #(5*CLK_PERIOD) rst_n = 1'b1;
      #(5*CLK_PERIOD);
      // R1 reset state
      chk_bank("R1 reset value");
      chk("R1 sda released", {7'd0, sda_oe}, 8'h00);

      // R4 burst write from index 2
      start_c();
      wr_byte(8'h6A, 1'b1, "R2 address ack");
      wr_byte(8'h02, 1'b1, "R3 index ack");
      wr_byte(8'h11, 1'b1, "R4 data ack");
      wr_byte(8'h22, 1'b1, "R4 data ack");
      stop_c();
      model[2] = 8'h11; model[3] = 8'h22;
      chk_bank("R4 burst write");

      // R6 read with repeated start, then R8 release after NACK
      start_c();
      wr_byte(8'h6A, 1'b1, "R6 address ack");
      wr_byte(8'h02, 1'b1, "R6 index ack");
      start_c();
      wr_byte(8'h6B, 1'b1, "R6 read address ack");
      rd_byte(8'h11, 1'b1, "R6 read byte 0");
      rd_byte(8'h22, 1'b1, "R6 read byte 1");
      rd_byte(8'hA4, 1'b0, "R6 read byte 2");
      wr_byte(8'hFF, 1'b0, "R8 no drive after nack");
      chk("R8 enable idle", {7'd0, sda_oe}, 8'h00);
      stop_c();

      // R2 mismatch
      start_c();
      wr_byte(8'h68, 1'b0, "R2 wrong address nack");
      wr_byte(8'h02, 1'b0, "R2 ignored after mismatch");
      stop_c();

      // R3 bad index
      start_c();
      wr_byte(8'h6A, 1'b1, "R3 address ack");
      wr_byte(8'h08, 1'b0, "R3 bad index nack");
      wr_byte(8'h55, 1'b0, "R3 data after bad index");
      stop_c();
      chk_bank("R3 bank untouched");

      // R5 write past top
      start_c();
      wr_byte(8'h6A, 1'b1, "R5 address ack");
      wr_byte(8'h06, 1'b1, "R5 index ack");
      wr_byte(8'h66, 1'b1, "R5 data ack");
      wr_byte(8'h77, 1'b1, "R5 top data ack");
      wr_byte(8'h88, 1'b0, "R5 past top nack");
      wr_byte(8'h99, 1'b0, "R5 idle after overrun");
      stop_c();
      model[6] = 8'h66; model[7] = 8'h77;
      chk_bank("R5 overrun discarded");

      // R7 read past top
      start_c();
      wr_byte(8'h6A, 1'b1, "R7 address ack");
      wr_byte(8'h05, 1'b1, "R7 index ack");
      start_c();
      wr_byte(8'h6B, 1'b1, "R7 read address ack");
      rd_byte(8'hA5, 1'b1, "R7 byte idx5");
      rd_byte(8'h66, 1'b1, "R7 byte idx6");
      rd_byte(8'h77, 1'b1, "R7 byte idx7");
      rd_byte(8'h77, 1'b1, "R7 repeat top");
      rd_byte(8'h77, 1'b0, "R7 repeat top again");
      stop_c();

      // R9 start mid-byte
      start_c();
      wr_byte(8'h6A, 1'b1, "R9 address ack");
      wr_byte(8'h01, 1'b1, "R9 index ack");
      bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      start_c();
      wr_byte(8'h6A, 1'b1, "R9 new address ack");
      wr_byte(8'h00, 1'b1, "R9 new index ack");
      wr_byte(8'h5A, 1'b1, "R9 data ack");
      stop_c();
      model[0] = 8'h5A;
      chk_bank("R9 partial byte dropped");

      // R10 stop mid-byte
      start_c();
      wr_byte(8'h6A, 1'b1, "R10 address ack");
      wr_byte(8'h03, 1'b1, "R10 index ack");
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
      stop_c();
      chk("R10 enable released", {7'd0, sda_oe}, 8'h00);
      chk_bank("R10 partial byte dropped");
      start_c();
      wr_byte(8'h6A, 1'b1, "R10 recovers address");
      wr_byte(8'h04, 1'b1, "R10 recovers index");
      wr_byte(8'h44, 1'b1, "R10 recovers data");
      stop_c();
      model[4] = 8'h44;
      chk_bank("R10 write after recovery");

      // R2 strap low
      addr_sel = 1'b0;
      #(Q);
      start_c();
      wr_byte(8'h6A, 1'b0, "R2 strap low old address");
      stop_c();
      start_c();
      wr_byte(8'h68, 1'b1, "R2 strap low address");
      wr_byte(8'h07, 1'b1, "R2 strap low index");
      wr_byte(8'h7E, 1'b1, "R2 strap low data");
      stop_c();
      model[7] = 8'h7E;
      chk_bank("R2 strap low write");

      #(4*CLK_PERIOD);
      chk("R11 enable moves only with SCL low", 8'(oe_hi_changes), 8'h00);
      chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      summary();
   end
endmodule